// File: doc/BRIEF.md
# Countdown Register Hazard Scoreboard

This block records the register writes that an in-order core has issued but not yet written back, so that decode can hold any instruction that reads a register whose result is still on its way. Each entry carries a countdown of the cycles left until its result is ready. It does not carry a plain busy bit. An entry holds a register identity made of a 3-bit file select and a 7-bit register number. The 7-bit number covers 128 general-purpose registers. When an entry reaches the end of its countdown it becomes due, and it must then win a register-file write port before it leaves the table.

Entries live in a small table of `NSLOT` slots. Each slot runs a three-state machine. Its states are `SLOT_FREE`, `SLOT_COUNT` and `SLOT_DUE`, and its transitions are:
- FREE→COUNT on allocation with a latency above one.
- FREE→DUE on allocation with a latency of zero or one.
- COUNT→COUNT while the count is above two, decrementing it.
- COUNT→DUE when the count reaches two.
- DUE→DUE while the slot is refused a write port.
- DUE→FREE when a port is granted.

A write-port arbiter grants at most `WR_PORTS` due slots per cycle, taking them in the order their instructions were issued. Decode presents up to three source registers each cycle. The block answers with a per-source busy flag and one combined stall.

Top module: `rdy_scoreboard`

## Requirements
- R1: While reset is held and in the first cycle after it, the table is empty. `src_busy`, `port_stall`, `stall` and `full` are all 0.
- R2: An issue is accepted at a rising edge when `iss_valid` is 1 and `full` is 0. From the next cycle the issued register is pending. A query made in the same cycle as the issue does not see the new entry.
- R3: An entry issued with latency L (1 to 15, where 0 counts as 1) becomes due L-1 cycles after its issue edge. It leaves at the next edge if it holds a port. With no contention it therefore stays pending for exactly L cycles.
- R4: `src_busy[k]` is 1 exactly when `src_valid[k]` is 1 and a pending entry matches both the file select and the register number of source k. Source k occupies bits `[3k+2:3k]` of `src_file` and `[7k+6:7k]` of `src_num`. A matching number in a different file does not match. The file codes are 0 integer, 1 floating point, 2 condition field, 3 fixed-point exception, 4 machine state, 5 floating-point control, 6 program counter and 7 special.
- R5: At most `WR_PORTS` due entries leave per edge, the earliest issued first. Refused due entries stay pending and stay due.
- R6: `port_stall` is 1 whenever more than `WR_PORTS` entries are due in the current cycle.
- R7: `stall` is the OR of `port_stall` and all bits of `src_busy`.
- R8: When one entry for a register leaves at the same edge as a new issue to that register, the register stays pending, because the new entry prevails.
- R9: `full` is 1 when all `NSLOT` slots hold entries. An issue presented while `full` is 1 creates no entry. A slot freed at an edge can be reused only from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | An instruction with a destination register is issued this cycle |
| iss_file | input | 3 | File select of the destination |
| iss_num | input | 7 | Register number of the destination |
| iss_lat | input | CNT_W | Cycles until the result is ready (0 counts as 1) |
| src_valid | input | NRD | Per-source query enable |
| src_file | input | NRD*3 | Packed file selects of the sources |
| src_num | input | NRD*7 | Packed register numbers of the sources |
| src_busy | output | NRD | Per-source pending flag |
| port_stall | output | 1 | More writes are due than there are write ports |
| stall | output | 1 | Combined hazard or port stall |
| full | output | 1 | No free slot; issues are dropped |

## Verification
Port arbitration and a new issue can land on the same edge. The bench provokes this in two ways. It issues to a register whose older entry is due in that same cycle. It also lines up three entries with latencies 3, 2 and 1 so that they fall due together, while more issues keep arriving. A reference list in the bench, kept in issue order, judges each cycle. It predicts which due entry is granted, which ones wait, and whether the re-issued register stays busy. A long run of seeded random issues and queries then repeats these collisions many times.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

    localparam int FILE_W = 3;
    localparam int NUM_W  = 7;

    typedef enum logic [FILE_W-1:0] {
        RF_INT     = 3'd0,
        RF_FLT     = 3'd1,
        RF_CONDF   = 3'd2,
        RF_FXEXC   = 3'd3,
        RF_MACHST  = 3'd4,
        RF_FPCTL   = 3'd5,
        RF_PCTR    = 3'd6,
        RF_SPECIAL = 3'd7
    } rfile_e;

    typedef struct packed {
        logic [FILE_W-1:0] file;
        logic [NUM_W-1:0]  num;
    } reg_id_t;

    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_COUNT = 2'd1,
        SLOT_DUE   = 2'd2
    } slot_state_e;

endpackage

// File: rtl/rsb_slot.sv
module rsb_slot
    import rsb_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  reg_id_t          alloc_id,
    input  logic [CNT_W-1:0] alloc_lat,
    input  logic             grant,
    output logic             busy,
    output logic             due,
    output reg_id_t          id
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    slot_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    reg_id_t          id_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SLOT_FREE: begin
                if (alloc) begin
                    if (alloc_lat > ONE) begin
                        state_d = SLOT_COUNT;
                        cnt_d   = alloc_lat;
                    end else begin
                        state_d = SLOT_DUE;
                        cnt_d   = ONE;
                    end
                end
            end
            SLOT_COUNT: begin
                if (cnt_q <= TWO) begin
                    state_d = SLOT_DUE;
                    cnt_d   = ONE;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
            SLOT_DUE: begin
                if (grant) begin
                    state_d = SLOT_FREE;
                end
            end
            default: state_d = SLOT_FREE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_FREE;
            cnt_q   <= '0;
            id_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (alloc && state_q == SLOT_FREE) begin
                id_q <= alloc_id;
            end
        end
    end

    // outputs
    always_comb begin
        busy = (state_q != SLOT_FREE);
        due  = (state_q == SLOT_DUE);
        id   = id_q;
    end

    // R3: a refused due slot keeps waiting
    a_r3_due_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_DUE && !grant) |=> (state_q == SLOT_DUE));

    // R3: counting slots step down by one or move to due
    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_COUNT) |=> (state_q == SLOT_DUE || cnt_q == $past(cnt_q) - ONE));

    // R5: only a due slot may be released
    a_r5_free_only_due: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_COUNT) |=> (state_q != SLOT_FREE));

endmodule

// File: rtl/rsb_alloc.sv
module rsb_alloc #(
    parameter int NSLOT = 8
) (
    input  logic [NSLOT-1:0] busy,
    input  logic             req,
    output logic [NSLOT-1:0] alloc,
    output logic             full
);

    logic found;

    always_comb begin
        alloc = '0;
        found = 1'b0;
        for (int i = 0; i < NSLOT; i++) begin
            if (!busy[i] && !found) begin
                alloc[i] = req;
                found    = 1'b1;
            end
        end
        full = &busy;
    end

endmodule

// File: rtl/rsb_age.sv
module rsb_age #(
    parameter int NSLOT    = 8,
    parameter int WR_PORTS = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSLOT-1:0] alloc,
    input  logic [NSLOT-1:0] due,
    output logic [NSLOT-1:0] grant
);

    // older_q[i][j] set: slot i was issued before slot j
    logic [NSLOT-1:0] older_q [NSLOT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLOT; i++) begin
                older_q[i] <= '0;
            end
        end else begin
            for (int s = 0; s < NSLOT; s++) begin
                if (alloc[s]) begin
                    for (int j = 0; j < NSLOT; j++) begin
                        older_q[s][j] <= 1'b0;
                        if (j != s) begin
                            older_q[j][s] <= 1'b1;
                        end
                    end
                end
            end
        end
    end

    always_comb begin
        logic [NSLOT-1:0] ahead;
        grant = '0;
        for (int i = 0; i < NSLOT; i++) begin
            for (int j = 0; j < NSLOT; j++) begin
                ahead[j] = older_q[j][i] & due[j];
            end
            grant[i] = due[i] && ($countones(ahead) < WR_PORTS);
        end
    end

    // R5: write-port budget respected
    a_r5_port_budget: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant) <= WR_PORTS);

    // R5: grants go only to due slots
    a_r5_grant_due: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~due) == '0);

endmodule

// File: rtl/rsb_lookup.sv
module rsb_lookup
    import rsb_pkg::*;
#(
    parameter int NSLOT = 8,
    parameter int NRD   = 3
) (
    input  logic [NSLOT-1:0]        slot_busy,
    input  reg_id_t                 slot_id [NSLOT],
    input  logic [NRD-1:0]          src_valid,
    input  logic [NRD*FILE_W-1:0]   src_file,
    input  logic [NRD*NUM_W-1:0]    src_num,
    output logic [NRD-1:0]          src_busy
);

    for (genvar k = 0; k < NRD; k++) begin : g_src
        reg_id_t          want;
        logic [NSLOT-1:0] hit;

        assign want.file = src_file[k*FILE_W +: FILE_W];
        assign want.num  = src_num[k*NUM_W +: NUM_W];

        for (genvar i = 0; i < NSLOT; i++) begin : g_cmp
            assign hit[i] = slot_busy[i] && (slot_id[i] == want);
        end

        assign src_busy[k] = src_valid[k] && (|hit);
    end

endmodule

// File: rtl/rdy_scoreboard.sv
module rdy_scoreboard
    import rsb_pkg::*;
#(
    parameter int NSLOT    = 8,
    parameter int WR_PORTS = 1,
    parameter int NRD      = 3,
    parameter int CNT_W    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  iss_valid,
    input  logic [FILE_W-1:0]     iss_file,
    input  logic [NUM_W-1:0]      iss_num,
    input  logic [CNT_W-1:0]      iss_lat,
    input  logic [NRD-1:0]        src_valid,
    input  logic [NRD*FILE_W-1:0] src_file,
    input  logic [NRD*NUM_W-1:0]  src_num,
    output logic [NRD-1:0]        src_busy,
    output logic                  port_stall,
    output logic                  stall,
    output logic                  full
);

    logic [NSLOT-1:0] slot_busy;
    logic [NSLOT-1:0] slot_due;
    logic [NSLOT-1:0] slot_grant;
    logic [NSLOT-1:0] slot_alloc;
    reg_id_t          slot_id [NSLOT];
    reg_id_t          new_id;

    assign new_id.file = iss_file;
    assign new_id.num  = iss_num;

    rsb_alloc #(.NSLOT(NSLOT)) u_alloc (
        .busy  (slot_busy),
        .req   (iss_valid),
        .alloc (slot_alloc),
        .full  (full)
    );

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        rsb_slot #(.CNT_W(CNT_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc     (slot_alloc[i]),
            .alloc_id  (new_id),
            .alloc_lat (iss_lat),
            .grant     (slot_grant[i]),
            .busy      (slot_busy[i]),
            .due       (slot_due[i]),
            .id        (slot_id[i])
        );
    end

    rsb_age #(.NSLOT(NSLOT), .WR_PORTS(WR_PORTS)) u_age (
        .clk   (clk),
        .rst_n (rst_n),
        .alloc (slot_alloc),
        .due   (slot_due),
        .grant (slot_grant)
    );

    rsb_lookup #(.NSLOT(NSLOT), .NRD(NRD)) u_lookup (
        .slot_busy (slot_busy),
        .slot_id   (slot_id),
        .src_valid (src_valid),
        .src_file  (src_file),
        .src_num   (src_num),
        .src_busy  (src_busy)
    );

    always_comb begin
        port_stall = ($countones(slot_due) > WR_PORTS);
        stall      = port_stall || (|src_busy);
    end

    // R2: an accepted issue adds exactly one occupied slot
    a_r2_one_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !full) |=> ($countones(slot_busy & ~$past(slot_busy)) == 1));

    // R9: an issue while full occupies nothing new
    a_r9_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && full) |=> ((slot_busy & ~$past(slot_busy)) == '0));

    // R6: an overflowed cycle leaves due work behind
    a_r6_overflow_left: assert property (@(posedge clk) disable iff (!rst_n)
        port_stall |=> (|slot_due));

    // R4: no busy report on an unused source
    a_r4_busy_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (src_busy & ~src_valid) == '0);

endmodule

// File: tb/rdy_scoreboard_bench.sv
module rdy_scoreboard_bench;

    localparam int NS  = 8;
    localparam int WRP = 1;
    localparam int NR  = 3;
    localparam int CW  = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           iss_valid = 1'b0;
    logic [2:0]     iss_file = '0;
    logic [6:0]     iss_num = '0;
    logic [CW-1:0]  iss_lat = '0;
    logic [NR-1:0]  src_valid = '0;
    logic [NR*3-1:0] src_file = '0;
    logic [NR*7-1:0] src_num = '0;
    logic [NR-1:0]  src_busy;
    logic           port_stall, stall, full;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    // reference list, earliest issue first
    int m_id [NS];
    int m_cnt [NS];
    int m_n = 0;

    always #2.5 clk = ~clk;

    rdy_scoreboard #(.NSLOT(NS), .WR_PORTS(WRP), .NRD(NR), .CNT_W(CW)) u_rdy_scoreboard (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_file(iss_file),
        .iss_num(iss_num), .iss_lat(iss_lat), .src_valid(src_valid),
        .src_file(src_file), .src_num(src_num), .src_busy(src_busy),
        .port_stall(port_stall), .stall(stall), .full(full)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit m_has(input int id);
        for (int i = 0; i < m_n; i++) if (m_id[i] == id) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int m_due();
        int c = 0;
        for (int i = 0; i < m_n; i++) if (m_cnt[i] == 1) c++;
        return c;
    endfunction

    function automatic int mk(input int f, input int n);
        return f * 128 + n;
    endfunction

    task automatic set_src(input int k, input bit v, input int f, input int n);
        src_valid[k] = v;
        src_file[k*3 +: 3] = 3'(f);
        src_num[k*7 +: 7] = 7'(n);
    endtask

    task automatic set_iss(input bit v, input int f, input int n, input int lat);
        iss_valid = v;
        iss_file = 3'(f);
        iss_num = 7'(n);
        iss_lat = CW'(lat);
    endtask

    // compare all outputs against the reference list (R4, R6, R7, R9)
    task automatic compare_model();
        int eb, ep;
        eb = 0;
        for (int k = 0; k < NR; k++) begin
            if (src_valid[k] && m_has(mk(src_file[k*3 +: 3], src_num[k*7 +: 7]))) eb |= (1 << k);
        end
        ep = (m_due() > WRP) ? 1 : 0;
        chk("R4 src_busy", int'(src_busy), eb);
        chk("R6 port_stall", int'(port_stall), ep);
        chk("R7 stall", int'(stall), (ep != 0 || eb != 0) ? 1 : 0);
        chk("R9 full", int'(full), (m_n == NS) ? 1 : 0);
    endtask

    // advance one edge and update the reference list (R3, R5, R8, R9)
    task automatic advance();
        int nid [NS];
        int ncnt [NS];
        int nn, granted;
        bit was_full;
        was_full = (m_n == NS);
        @(posedge clk);
        nn = 0;
        granted = 0;
        for (int i = 0; i < m_n; i++) begin
            if (m_cnt[i] == 1) begin
                if (granted < WRP) granted++;
                else begin nid[nn] = m_id[i]; ncnt[nn] = 1; nn++; end
            end else begin
                nid[nn] = m_id[i]; ncnt[nn] = m_cnt[i] - 1; nn++;
            end
        end
        if (iss_valid && !was_full) begin
            nid[nn] = mk(iss_file, iss_num);
            ncnt[nn] = (iss_lat == 0) ? 1 : int'(iss_lat);
            nn++;
        end
        for (int i = 0; i < nn; i++) begin m_id[i] = nid[i]; m_cnt[i] = ncnt[i]; end
        m_n = nn;
    endtask

    task automatic begin_cycle();
        @(negedge clk);
        set_iss(0, 0, 0, 0);
        src_valid = '0;
    endtask

    task automatic settle();
        #0.5;
        compare_model();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 src_busy in reset", int'(src_busy), 0);
        chk("R1 stall in reset", int'(stall), 0);
        chk("R1 full in reset", int'(full), 0);
        rst_n = 1'b1;
        begin_cycle();
        set_src(0, 1, 0, 0);
        settle();
        chk("R1 port_stall after reset", int'(port_stall), 0);
        chk("R1 src_busy after reset", int'(src_busy), 0);
        advance();

        // R2/R3: integer register 3, latency 2, read by the next instruction
        begin_cycle();
        set_iss(1, 0, 3, 2);
        set_src(0, 1, 0, 3);
        settle();
        chk("R2 same-cycle query unseen", int'(src_busy[0]), 0);
        advance();
        begin_cycle();
        set_src(0, 1, 0, 3);
        set_src(1, 1, 1, 3);
        settle();
        chk("R2 pending after issue", int'(src_busy[0]), 1);
        chk("R4 other file not matched", int'(src_busy[1]), 0);
        advance();
        begin_cycle();
        set_src(0, 1, 0, 3);
        settle();
        chk("R3 still pending second cycle", int'(src_busy[0]), 1);
        advance();
        begin_cycle();
        set_src(0, 1, 0, 3);
        settle();
        chk("R3 cleared after latency", int'(src_busy[0]), 0);
        advance();

        // R5/R6: three entries fall due together
        begin_cycle(); set_iss(1, 0, 10, 3); settle(); advance();
        begin_cycle(); set_iss(1, 0, 11, 2); settle(); advance();
        begin_cycle(); set_iss(1, 0, 12, 1); settle(); advance();
        begin_cycle();
        set_src(0, 1, 0, 10); set_src(1, 1, 0, 11); set_src(2, 1, 0, 12);
        settle();
        chk("R6 overflow stall", int'(port_stall), 1);
        chk("R5 all three pending", int'(src_busy), 7);
        advance();
        begin_cycle();
        set_src(0, 1, 0, 10); set_src(1, 1, 0, 11); set_src(2, 1, 0, 12);
        settle();
        chk("R5 oldest retired first", int'(src_busy), 6);
        chk("R6 still overflowing", int'(port_stall), 1);
        advance();
        begin_cycle();
        set_src(0, 1, 0, 10); set_src(1, 1, 0, 11); set_src(2, 1, 0, 12);
        settle();
        chk("R5 second retired", int'(src_busy), 4);
        chk("R6 within budget", int'(port_stall), 0);
        advance();
        begin_cycle(); settle(); advance();

        // R8: retire and re-issue of the same register on one edge
        begin_cycle(); set_iss(1, 2, 20, 1); settle(); advance();
        begin_cycle();
        set_iss(1, 2, 20, 2);
        set_src(0, 1, 2, 20);
        settle();
        chk("R8 due entry visible", int'(src_busy[0]), 1);
        advance();
        begin_cycle();
        set_src(0, 1, 2, 20);
        settle();
        chk("R8 new entry prevails", int'(src_busy[0]), 1);
        advance();
        begin_cycle(); settle(); advance();
        begin_cycle();
        set_src(0, 1, 2, 20);
        settle();
        chk("R8 cleared later", int'(src_busy[0]), 0);
        advance();

        // R9: fill the table with long latencies, then try one more
        for (int i = 0; i < NS; i++) begin
            begin_cycle(); set_iss(1, 5, 40 + i, 15); settle(); advance();
        end
        begin_cycle();
        set_iss(1, 7, 127, 3);
        settle();
        chk("R9 full asserted", int'(full), 1);
        advance();
        begin_cycle();
        set_src(0, 1, 7, 127);
        settle();
        chk("R9 dropped issue not pending", int'(src_busy[0]), 0);
        advance();
        while (m_n > 0) begin begin_cycle(); settle(); advance(); end

        // random mix against the reference list
        void'($urandom(32'h5EED_0A1C));
        for (int c = 0; c < 4000; c++) begin
            begin_cycle();
            set_iss(($urandom % 10) < 6, $urandom % 3, $urandom % 8,
                    (($urandom % 8) == 0) ? $urandom % 16 : $urandom % 4);
            for (int k = 0; k < NR; k++) begin
                if (m_n > 0 && ($urandom % 2)) begin
                    int p;
                    p = $urandom % m_n;
                    set_src(k, $urandom % 4 != 0, m_id[p] / 128, m_id[p] % 128);
                end else begin
                    set_src(k, $urandom % 2, $urandom % 3, $urandom % 8);
                end
            end
            settle();
            advance();
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule